// File: doc/BRIEF.md
# Serial Flash Recovery Clock Sequencer

This block drives the chip select, serial clock and two data lines (DQ0 and DQ3) of a serial NOR flash directly, bit by bit, to bring a device that is stuck in an unknown interface mode back to plain single-line SPI. A single start pulse runs a fixed preamble of six chip-select-framed clock bursts. One further burst follows, and its length is chosen by the `mode` input captured at start. Throughout the sequence both data lines are driven high, so the device samples only ones.

Pulses are counted one clock edge at a time, not in bytes, so every burst has exactly the length required. Two parameters set the serial clock half period and the chip-select high gap, both counted in system clocks. An elaboration-time check confirms that the gap covers the minimum deselect time at the stated system clock frequency. Once started, the sequence always runs to completion. When the last burst closes, a one-cycle `done` pulse is issued.

Top module: `sflash_rcv_seq`

## Requirements
- R1: A synchronous active-low reset, applied at any time including mid-sequence, leaves cs_n=1, sclk=0, dq0_oe=dq3_oe=0, dq0=dq3=0, busy=0 and done=0 after the clock edge that samples it.
- R2: The preamble is six separate cs_n-low bursts carrying exactly 7, 9, 13, 17, 25 and 33 sclk rising edges, in that order.
- R3: With mode=0 (power-loss recovery) captured at start, exactly one seventh burst of 8 sclk rising edges follows the preamble.
- R4: With mode=1 (interface rescue) captured at start, exactly one seventh burst of 16 sclk rising edges follows the preamble.
- R5: Whenever cs_n is low, dq0_oe, dq0, dq3_oe and dq3 are all 1. In the cycle done is high and afterwards, all four are 0.
- R6: Between consecutive bursts cs_n stays high for exactly GAP_CYCLES system clocks. GAP_CYCLES × clock period must be at least 50 ns, which is checked at elaboration.
- R7: sclk is low whenever cs_n is high. Inside a burst, every sclk high phase and every sclk low phase lasts HALF_PERIOD clocks, including the low lead before the first rising edge and the low tail after the last falling edge.
- R8: While busy, start is ignored and changes on mode have no effect. The final burst length follows the mode sampled with the accepted start.
- R9: busy is 1 from the cycle after start is accepted until the last burst ends. done is a single-cycle pulse with cs_n high, appearing HALF_PERIOD×(Σ(2n+1) over the seven bursts) + 6×GAP_CYCLES cycles after the accepting edge.
- R10: Without a start pulse the block stays idle, with cs_n high and sclk low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Synchronous active-low reset |
| start | input | 1 | Starts a sequence when idle |
| mode | input | 1 | 0 = power-loss recovery tail, 1 = interface rescue tail |
| cs_n | output | 1 | Flash chip select, active low |
| sclk | output | 1 | Flash serial clock, idles low |
| dq0_oe | output | 1 | Output enable for DQ0 |
| dq0 | output | 1 | DQ0 drive value |
| dq3_oe | output | 1 | Output enable for DQ3 |
| dq3 | output | 1 | DQ3 drive value |
| busy | output | 1 | Sequence in progress |
| done | output | 1 | One-cycle pulse when the sequence completes |

## Verification
Every output comes from a register. The first burst therefore shows cs_n low in the first cycle after the edge that accepts start, and busy rises in that same cycle. The bench counts cycles from that first sample and tracks the length of each sclk phase, each gap and each burst as it goes. done is due exactly HALF_PERIOD×Σ(2n+1)+6×GAP_CYCLES samples later, and the released data lines are checked in that sample and in the one after it. Reset effects are sampled on the falling edge that follows the reset edge.

// File: rtl/sfr_pkg.sv
package sfr_pkg;

    localparam int STEP_COUNT = 7;
    localparam int STEP_W     = $clog2(STEP_COUNT);
    localparam int PULSE_W    = 6;

    localparam logic MODE_POWER_LOSS = 1'b0;
    localparam logic MODE_RESCUE     = 1'b1;

    typedef enum logic [2:0] {
        PH_IDLE,
        PH_LEAD,
        PH_HIGH,
        PH_LOW,
        PH_GAP,
        PH_FIN
    } phase_e;

    typedef struct packed {
        phase_e            phase;
        logic [STEP_W-1:0] step;
        logic              mode;
        logic              cs_n;
        logic              sclk;
        logic              drv;
        logic              done;
    } ctl_t;

    localparam ctl_t CTL_RESET = '{
        phase: PH_IDLE,
        step:  '0,
        mode:  1'b0,
        cs_n:  1'b1,
        sclk:  1'b0,
        drv:   1'b0,
        done:  1'b0
    };

endpackage

// File: rtl/sfr_step_table.sv
module sfr_step_table
    import sfr_pkg::*;
(
    input  logic [STEP_W-1:0]  step,
    input  logic               mode,
    output logic [PULSE_W-1:0] pulses,
    output logic               last
);

    // Preamble lengths are fixed; the final step length depends on the latched mode.
    always_comb begin
        unique case (step)
            STEP_W'(0): pulses = PULSE_W'(7);
            STEP_W'(1): pulses = PULSE_W'(9);
            STEP_W'(2): pulses = PULSE_W'(13);
            STEP_W'(3): pulses = PULSE_W'(17);
            STEP_W'(4): pulses = PULSE_W'(25);
            STEP_W'(5): pulses = PULSE_W'(33);
            default:    pulses = (mode == MODE_RESCUE) ? PULSE_W'(16) : PULSE_W'(8);
        endcase
    end

    assign last = (step == STEP_W'(STEP_COUNT - 1));

endmodule

// File: rtl/sfr_timer.sv
module sfr_timer #(
    parameter int WIDTH = 4
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             load,
    input  logic [WIDTH-1:0] load_val,
    output logic             expired
);

    logic [WIDTH-1:0] cnt_d, cnt_q;

    always_comb begin
        cnt_d = cnt_q;
        if (load) begin
            cnt_d = load_val;
        end else if (cnt_q != '0) begin
            cnt_d = cnt_q - 1'b1;
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) cnt_q <= '0;
        else        cnt_q <= cnt_d;
    end

    assign expired = (cnt_q == '0);

    // R7: a phase timer never wraps below zero
    p_timer_no_wrap_r7: assert property (@(posedge clk) disable iff (!rst_n)
        (!load && cnt_q == '0) |=> (cnt_q == '0));

endmodule

// File: rtl/sfr_pulse_counter.sv
module sfr_pulse_counter
    import sfr_pkg::*;
(
    input  logic               clk,
    input  logic               rst_n,
    input  logic               load,
    input  logic [PULSE_W-1:0] load_len,
    input  logic               dec,
    output logic               last_pulse
);

    logic [PULSE_W-1:0] left_d, left_q;

    always_comb begin
        left_d = left_q;
        if (load)     left_d = load_len - 1'b1;
        else if (dec) left_d = left_q - 1'b1;
    end

    always_ff @(posedge clk) begin
        if (!rst_n) left_q <= '0;
        else        left_q <= left_d;
    end

    assign last_pulse = (left_q == '0);

    // R2: a pulse is never consumed when none remain in the burst
    p_no_underflow_r2: assert property (@(posedge clk) disable iff (!rst_n)
        dec |-> (left_q != '0));

endmodule

// File: rtl/sflash_rcv_seq.sv
module sflash_rcv_seq
    import sfr_pkg::*;
#(
    parameter int HALF_PERIOD = 2,
    parameter int GAP_CYCLES  = 8,
    parameter int SYS_CLK_MHZ = 125,
    parameter int MIN_GAP_NS  = 50
) (
    input  logic clk,
    input  logic rst_n,
    input  logic start,
    input  logic mode,
    output logic cs_n,
    output logic sclk,
    output logic dq0_oe,
    output logic dq0,
    output logic dq3_oe,
    output logic dq3,
    output logic busy,
    output logic done
);

    localparam int TMR_MAX = (HALF_PERIOD > GAP_CYCLES) ? HALF_PERIOD : GAP_CYCLES;
    localparam int TMR_W   = (TMR_MAX > 1) ? $clog2(TMR_MAX) : 1;
    localparam logic [TMR_W-1:0] HALF_M1 = TMR_W'(HALF_PERIOD - 1);
    localparam logic [TMR_W-1:0] GAP_M1  = TMR_W'(GAP_CYCLES - 1);
    localparam bit GAP_OK = (GAP_CYCLES * 1000) >= (MIN_GAP_NS * SYS_CLK_MHZ);

    // R6: deselect gap must cover the minimum time at the stated clock frequency
    if (!GAP_OK) begin : g_gap_too_short
        $error("GAP_CYCLES too short for minimum chip-select high time");
    end
    if (HALF_PERIOD < 1) begin : g_half_bad
        $error("HALF_PERIOD must be at least 1");
    end

    ctl_t q, d;

    logic               tmr_load;
    logic [TMR_W-1:0]   tmr_val;
    logic               tmr_exp;
    logic               pls_load;
    logic               pls_dec;
    logic               pls_last;
    logic [PULSE_W-1:0] step_len;
    logic               step_last;

    sfr_step_table u_table (
        .step   (q.step),
        .mode   (q.mode),
        .pulses (step_len),
        .last   (step_last)
    );

    sfr_timer #(.WIDTH(TMR_W)) u_timer (
        .clk      (clk),
        .rst_n    (rst_n),
        .load     (tmr_load),
        .load_val (tmr_val),
        .expired  (tmr_exp)
    );

    sfr_pulse_counter u_pulses (
        .clk        (clk),
        .rst_n      (rst_n),
        .load       (pls_load),
        .load_len   (step_len),
        .dec        (pls_dec),
        .last_pulse (pls_last)
    );

    always_comb begin
        d        = q;
        d.done   = 1'b0;
        tmr_load = 1'b0;
        tmr_val  = HALF_M1;
        pls_load = 1'b0;
        pls_dec  = 1'b0;
        unique case (q.phase)
            PH_IDLE: begin
                if (start) begin
                    d.phase  = PH_LEAD;
                    d.step   = '0;
                    d.mode   = mode;
                    d.cs_n   = 1'b0;
                    d.drv    = 1'b1;
                    tmr_load = 1'b1;
                    pls_load = 1'b1;
                end
            end
            PH_LEAD: begin
                if (tmr_exp) begin
                    d.phase  = PH_HIGH;
                    d.sclk   = 1'b1;
                    tmr_load = 1'b1;
                end
            end
            PH_HIGH: begin
                if (tmr_exp) begin
                    d.phase  = PH_LOW;
                    d.sclk   = 1'b0;
                    tmr_load = 1'b1;
                end
            end
            PH_LOW: begin
                if (tmr_exp) begin
                    if (!pls_last) begin
                        d.phase  = PH_HIGH;
                        d.sclk   = 1'b1;
                        tmr_load = 1'b1;
                        pls_dec  = 1'b1;
                    end else if (step_last) begin
                        d.phase = PH_FIN;
                        d.cs_n  = 1'b1;
                        d.drv   = 1'b0;
                        d.done  = 1'b1;
                        d.step  = '0;
                    end else begin
                        d.phase  = PH_GAP;
                        d.cs_n   = 1'b1;
                        d.step   = q.step + 1'b1;
                        tmr_load = 1'b1;
                        tmr_val  = GAP_M1;
                    end
                end
            end
            PH_GAP: begin
                if (tmr_exp) begin
                    d.phase  = PH_LEAD;
                    d.cs_n   = 1'b0;
                    tmr_load = 1'b1;
                    pls_load = 1'b1;
                end
            end
            PH_FIN: begin
                d.phase = PH_IDLE;
            end
            default: begin
                d = CTL_RESET;
            end
        endcase
    end

    always_ff @(posedge clk) begin
        if (!rst_n) q <= CTL_RESET;
        else        q <= d;
    end

    assign cs_n   = q.cs_n;
    assign sclk   = q.sclk;
    assign dq0_oe = q.drv;
    assign dq0    = q.drv;
    assign dq3_oe = q.drv;
    assign dq3    = q.drv;
    assign busy   = (q.phase != PH_IDLE) && (q.phase != PH_FIN);
    assign done   = q.done;

    // R7: the serial clock only toggles inside a selected frame
    p_sclk_in_frame_r7: assert property (@(posedge clk) disable iff (!rst_n)
        sclk |-> !cs_n);

    // R7: chip select is never released while the clock is high
    p_cs_rise_clk_low_r7: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(cs_n) |-> !sclk);

    // R5: both data lines drive ones for the whole frame
    p_data_ones_r5: assert property (@(posedge clk) disable iff (!rst_n)
        !cs_n |-> (dq0_oe && dq0 && dq3_oe && dq3));

    // R5: data lines are released when the sequence completes
    p_release_at_done_r5: assert property (@(posedge clk) disable iff (!rst_n)
        done |-> (!dq0_oe && !dq3_oe && cs_n && !busy));

    // R9: completion flag lasts one cycle
    p_done_pulse_r9: assert property (@(posedge clk) disable iff (!rst_n)
        done |=> !done);

    // R8: the captured mode stays fixed for the whole run
    p_mode_held_r8: assert property (@(posedge clk) disable iff (!rst_n)
        (busy && $past(busy)) |-> $stable(q.mode));

    // R10: leaving idle requires a start request
    p_idle_needs_start_r10: assert property (@(posedge clk) disable iff (!rst_n)
        (q.phase == PH_IDLE && !start) |=> (q.phase == PH_IDLE));

endmodule

// File: tb/sflash_rcv_seq_tb.sv
module sflash_rcv_seq_tb;

    localparam int HALF = 2;
    localparam int GAP  = 8;

    typedef struct packed {
        logic       mode;
        logic [1:0] poke;      // 0 none, 1 repeat start, 2 start with flipped mode
        logic [5:0] final_len;
    } vec_t;

    localparam vec_t VECS [4] = '{
        '{mode: 1'b0, poke: 2'd0, final_len: 6'd8},
        '{mode: 1'b1, poke: 2'd0, final_len: 6'd16},
        '{mode: 1'b0, poke: 2'd2, final_len: 6'd8},
        '{mode: 1'b1, poke: 2'd1, final_len: 6'd16}
    };

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic start = 1'b0;
    logic mode = 1'b0;
    logic cs_n, sclk, dq0_oe, dq0, dq3_oe, dq3, busy, done;

    int n_chk = 0;
    int n_err = 0;

    always #4 clk = ~clk;

    sflash_rcv_seq #(.HALF_PERIOD(HALF), .GAP_CYCLES(GAP)) u_dut (
        .clk(clk), .rst_n(rst_n), .start(start), .mode(mode),
        .cs_n(cs_n), .sclk(sclk), .dq0_oe(dq0_oe), .dq0(dq0),
        .dq3_oe(dq3_oe), .dq3(dq3), .busy(busy), .done(done)
    );

    task automatic check(input bit ok, input string req, input int act, input int exp);
        n_chk++;
        if (!ok) begin
            n_err++;
            $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
        end
    endtask

    function automatic int pre_len(input int i);
        case (i)
            0: return 7;   1: return 9;   2: return 13;
            3: return 17;  4: return 25;  default: return 33;
        endcase
    endfunction

    function automatic int done_at(input int fin);
        int s = 2 * fin + 1;
        for (int i = 0; i < 6; i++) s += 2 * pre_len(i) + 1;
        return HALF * s + 6 * GAP;
    endfunction

    task automatic check_reset_outs(input string req);
        check(cs_n === 1'b1 && sclk === 1'b0, req, {30'd0, cs_n, sclk}, 2);
        check(dq0_oe === 1'b0 && dq3_oe === 1'b0 && dq0 === 1'b0 && dq3 === 1'b0,
              req, {28'd0, dq0_oe, dq0, dq3_oe, dq3}, 0);
        check(busy === 1'b0 && done === 1'b0, req, {30'd0, busy, done}, 0);
    endtask

    task automatic run_vec(input vec_t v);
        int blen [8];
        int nb = 0, pulses = 0, hi_run = 0, lo_run = 0, gap = 0, cyc = 0, done_cyc = -1;
        int bad_dq = 0, bad_hi = 0, bad_lo = 0, bad_gap = 0, rel_bad = 0;
        logic pcs = 1'b1, psclk = 1'b0;
        for (int i = 0; i < 8; i++) blen[i] = 0;
        @(negedge clk);
        start = 1'b1;
        mode  = v.mode;
        @(negedge clk);
        start = 1'b0;
        check(busy === 1'b1 && cs_n === 1'b0, "R9 busy after start", {30'd0, busy, cs_n}, 2);
        while (done_cyc < 0 && cyc < 5000) begin
            if (!cs_n) begin
                if (!(dq0_oe && dq0 && dq3_oe && dq3)) bad_dq++;
                if (pcs) begin
                    if (nb > 0 && gap != GAP) bad_gap++;
                    pulses = 0; lo_run = 0; hi_run = 0;
                end
                if (sclk) begin
                    if (!psclk) begin
                        pulses++;
                        if (lo_run != HALF) bad_lo++;
                        lo_run = 0;
                    end
                    hi_run++;
                end else begin
                    if (psclk) begin
                        if (hi_run != HALF) bad_hi++;
                        hi_run = 0;
                    end
                    lo_run++;
                end
            end else begin
                if (!pcs) begin
                    if (lo_run != HALF) bad_lo++;
                    if (psclk) bad_hi++;
                    if (nb < 8) blen[nb] = pulses;
                    nb++;
                    gap = 0;
                end
                gap++;
                if (sclk) bad_hi++;
            end
            if (done) begin
                done_cyc = cyc;
                if (!(cs_n && !dq0_oe && !dq3_oe && !dq0 && !dq3 && !busy)) rel_bad++;
            end
            if (v.poke != 2'd0 && cyc == 100) begin
                start = 1'b1;
                mode  = (v.poke == 2'd2) ? ~v.mode : v.mode;
            end
            if (cyc == 101) begin
                start = 1'b0;
                mode  = v.mode;
            end
            pcs = cs_n;
            psclk = sclk;
            cyc++;
            if (done_cyc < 0) @(negedge clk);
        end
        check(nb == 7, "R2 burst count", nb, 7);
        for (int i = 0; i < 6; i++) check(blen[i] == pre_len(i), "R2 preamble length", blen[i], pre_len(i));
        if (v.poke != 2'd0)
            check(blen[6] == int'(v.final_len), "R8 tail length after ignored start", blen[6], int'(v.final_len));
        else if (v.mode)
            check(blen[6] == 16, "R4 rescue tail length", blen[6], 16);
        else
            check(blen[6] == 8, "R3 power-loss tail length", blen[6], 8);
        check(bad_dq == 0, "R5 data lines high in frame", bad_dq, 0);
        check(rel_bad == 0, "R5 release at done", rel_bad, 0);
        check(bad_gap == 0, "R6 gap length", bad_gap, 0);
        check(bad_hi == 0 && bad_lo == 0, "R7 clock phases", bad_hi + bad_lo, 0);
        check(done_cyc == done_at(int'(v.final_len)), "R9 done timing", done_cyc, done_at(int'(v.final_len)));
        @(negedge clk);
        check(done === 1'b0 && busy === 1'b0 && cs_n === 1'b1, "R9 done one cycle", {29'd0, done, busy, cs_n}, 1);
        check(dq0_oe === 1'b0 && dq3_oe === 1'b0, "R5 lines stay released", {30'd0, dq0_oe, dq3_oe}, 0);
    endtask

    initial begin : watchdog
        repeat (20000) @(posedge clk);
        n_chk++;
        n_err++;
        $display("FAIL watchdog actual=%0d expected=%0d", 20000, 0);
        $display("Result: errors=%0d of %0d checks", n_err, n_chk);
        $finish;
    end

    initial begin : stim
        repeat (3) @(negedge clk);
        check_reset_outs("R1 reset state");
        rst_n = 1'b1;
        // R10: no activity without start
        for (int i = 0; i < 20; i++) begin
            @(negedge clk);
            if (cs_n !== 1'b1 || sclk !== 1'b0 || busy !== 1'b0) begin
                check(1'b0, "R10 idle without start", {30'd0, cs_n, sclk}, 2);
            end
        end
        check(cs_n === 1'b1 && sclk === 1'b0, "R10 idle without start", {30'd0, cs_n, sclk}, 2);

        for (int k = 0; k < 4; k++) run_vec(VECS[k]);

        // R1: reset in the middle of a run
        @(negedge clk);
        start = 1'b1;
        mode  = 1'b1;
        @(negedge clk);
        start = 1'b0;
        repeat (60) @(negedge clk);
        rst_n = 1'b0;
        @(negedge clk);
        check_reset_outs("R1 reset mid-run");
        rst_n = 1'b1;
        repeat (5) @(negedge clk);
        check(cs_n === 1'b1 && busy === 1'b0, "R10 idle after reset", {30'd0, cs_n, busy}, 2);

        run_vec(VECS[0]);

        $display("Result: errors=%0d of %0d checks", n_err, n_chk);
        $finish;
    end

endmodule